// File: doc/BRIEF.md
# Flash Read-Ahead Address Sequencer

This block sits inside a flash controller and converts pipelined read-ahead and write-ahead commands from a host into a stream of device page requests. A command carries a direction, a starting block address, a starting page address and a page count. Accepted commands wait in a small queue that both directions share. The command at the head of the queue stays there until the host has transferred every one of its pages.

For a read-ahead command, a device load request for the first page goes out as soon as the command reaches an idle head. After that, each host read access consumes one page and triggers a cache read request for the following page, so the device always stays one page ahead of the host. No request goes beyond the command's last page. A write-ahead command issues nothing at start. Each host write access commits one page to the device.

Addresses advance in one of two orders. In consecutive order the page address counts up and carries into the block address. In plane-interleaved order the page address holds while the block address walks across the planes, then the block address returns to its start and the page address steps. A mode flag selects the order, and it can only be changed while the queue is empty.

Top module: `flash_ra_seq`

## Requirements
- R1: The queue holds QDEPTH (default 4) commands of either direction. `cmd_full_o` is high while QDEPTH commands are held. A command presented while the queue is full is not queued, and `cmd_err_o` pulses for one cycle after the edge at which it was presented.
- R2: A command with a page count of zero is dropped. In plane mode (`mode_o`=1), a command whose block address or page count is not a multiple of 2^PLANE_LOG2 is also dropped. A dropped command is not queued, and `drop_err_o` pulses for one cycle after the edge at which it was presented.
- R3: A read-ahead command (`cmd_write_i`=0) that reaches an idle queue head produces a load request (`dev_req_o`=1, `dev_load_o`=1, `dev_wr_o`=0) at its start address. The request is registered on the clock edge after the edge at which the command was accepted.
- R4: In consecutive mode (`mode_o`=0), page k of a command is at page (pg+k) mod 2^PG_W, and its block address is the start block plus the carry out of that sum.
- R5: In plane mode, page k of a command is at block (blk + k mod 2^PLANE_LOG2) and page (pg + k div 2^PLANE_LOG2).
- R6: A host read access (`host_xfer_i`=1, `host_xfer_wr_i`=0) to an active read-ahead command makes `xfer_ok_o` pulse one cycle later with the consumed page's address. In that same cycle a cache read request (`dev_load_o`=0, `dev_wr_o`=0) goes out for the next page, unless the consumed page was the last one.
- R7: A write-ahead command issues no request when it starts. Each host write access to it makes a write request (`dev_wr_o`=1, `dev_load_o`=0) at the consumed page's address, in the same cycle as the `xfer_ok_o` pulse.
- R8: The next queued command does not start until every page of the current command has been consumed. `busy_o` is high while the queue holds any command.
- R9: A host access made with no active command, or with a direction that differs from the active command's, is ignored. It produces no `xfer_ok_o` and no `dev_req_o`.
- R10: A mode write (`mode_wr_i`) takes effect only while the queue is empty. A mode write made at any other time leaves `mode_o` unchanged and sets `mode_err_o`, which stays set until reset.
- R11: After reset the queue is empty, `mode_o`=0, and all pulse outputs and `mode_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command presented this cycle |
| cmd_write_i | input | 1 | 1 = write-ahead, 0 = read-ahead |
| cmd_blk_i | input | BLK_W | Start block address |
| cmd_pg_i | input | PG_W | Start page address |
| cmd_cnt_i | input | CNT_W | Page count |
| cmd_full_o | output | 1 | Queue full |
| cmd_err_o | output | 1 | Pulse: command rejected because the queue was full |
| drop_err_o | output | 1 | Pulse: command dropped (zero count or misaligned) |
| busy_o | output | 1 | Queue holds at least one command |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_val_i | input | 1 | Mode value: 1 = plane-interleaved, 0 = consecutive |
| mode_o | output | 1 | Current mode |
| mode_err_o | output | 1 | Sticky: mode write attempted while the queue was not empty |
| host_xfer_i | input | 1 | Host data access strobe |
| host_xfer_wr_i | input | 1 | Host access direction: 1 = write, 0 = read |
| xfer_ok_o | output | 1 | Pulse: a page was consumed |
| xfer_blk_o | output | BLK_W | Block address of the consumed page |
| xfer_pg_o | output | PG_W | Page address of the consumed page |
| dev_req_o | output | 1 | Pulse: device request |
| dev_wr_o | output | 1 | Request is a page write |
| dev_load_o | output | 1 | Request is the first load of a read-ahead command |
| dev_blk_o | output | BLK_W | Request block address |
| dev_pg_o | output | PG_W | Request page address |

## Verification
The bench builds the block with PG_W=3 and PLANE_LOG2=2. An 8-page field lets a short consecutive command carry from page 7 into the next block. Four planes make the plane walk, its return to the start block, and the alignment modulo four all visible within one 8-page command. QDEPTH stays at 4, so filling the queue, rejecting a fifth command, and draining a mix of read and write commands in order all fit in a short run.

// File: rtl/ra_seq_pkg.sv
`timescale 1ns/1ps
package ra_seq_pkg;
  typedef enum logic [1:0] {
    CHK_OK       = 2'd0,
    CHK_ZERO     = 2'd1,
    CHK_MISALIGN = 2'd2
  } chk_e;
endpackage

// File: rtl/ra_cmd_fifo.sv
`timescale 1ns/1ps
module ra_cmd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ra_cmd_check.sv
`timescale 1ns/1ps
module ra_cmd_check
  import ra_seq_pkg::*;
#(
  parameter int BLK_W  = 10,
  parameter int CNT_W  = 8,
  parameter int PLANES = 2
) (
  input  logic             mp_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [CNT_W-1:0] cnt_i,
  output chk_e             verdict_o
);
  logic blk_off, cnt_off;
  assign blk_off = (blk_i & BLK_W'(PLANES - 1)) != '0;
  assign cnt_off = (cnt_i & CNT_W'(PLANES - 1)) != '0;

  always_comb begin
    if (cnt_i == '0)                  verdict_o = CHK_ZERO;
    else if (mp_i && (blk_off || cnt_off)) verdict_o = CHK_MISALIGN;
    else                              verdict_o = CHK_OK;
  end
endmodule

// File: rtl/ra_addr_step.sv
`timescale 1ns/1ps
module ra_addr_step #(
  parameter int BLK_W  = 10,
  parameter int PG_W   = 6,
  parameter int PL_W   = 1,
  parameter int PLANES = 2
) (
  input  logic             mp_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  pg_i,
  input  logic [PL_W-1:0]  plane_i,
  input  logic [BLK_W-1:0] base_i,
  output logic [BLK_W-1:0] blk_o,
  output logic [PG_W-1:0]  pg_o,
  output logic [PL_W-1:0]  plane_o
);
  logic last_plane;
  assign last_plane = (plane_i == PL_W'(PLANES - 1));

  always_comb begin
    if (!mp_i) begin
      // consecutive: page carries into block
      {blk_o, pg_o} = {blk_i, pg_i} + (BLK_W + PG_W)'(1);
      plane_o       = '0;
    end else if (last_plane) begin
      blk_o   = base_i;
      pg_o    = pg_i + PG_W'(1);
      plane_o = '0;
    end else begin
      blk_o   = blk_i + BLK_W'(1);
      pg_o    = pg_i;
      plane_o = plane_i + PL_W'(1);
    end
  end
endmodule

// File: rtl/flash_ra_seq.sv
`timescale 1ns/1ps
module flash_ra_seq
  import ra_seq_pkg::*;
#(
  parameter int BLK_W      = 10,
  parameter int PG_W       = 6,
  parameter int CNT_W      = 8,
  parameter int QDEPTH     = 4,
  parameter int PLANE_LOG2 = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_write_i,
  input  logic [BLK_W-1:0] cmd_blk_i,
  input  logic [PG_W-1:0]  cmd_pg_i,
  input  logic [CNT_W-1:0] cmd_cnt_i,
  output logic             cmd_full_o,
  output logic             cmd_err_o,
  output logic             drop_err_o,
  output logic             busy_o,
  input  logic             mode_wr_i,
  input  logic             mode_val_i,
  output logic             mode_o,
  output logic             mode_err_o,
  input  logic             host_xfer_i,
  input  logic             host_xfer_wr_i,
  output logic             xfer_ok_o,
  output logic [BLK_W-1:0] xfer_blk_o,
  output logic [PG_W-1:0]  xfer_pg_o,
  output logic             dev_req_o,
  output logic             dev_wr_o,
  output logic             dev_load_o,
  output logic [BLK_W-1:0] dev_blk_o,
  output logic [PG_W-1:0]  dev_pg_o
);
  localparam int PLANES = 1 << PLANE_LOG2;
  localparam int PL_W   = (PLANE_LOG2 > 0) ? PLANE_LOG2 : 1;
  localparam int CMD_W  = 1 + BLK_W + PG_W + CNT_W;

  logic             mode_q, mode_err_q;
  logic             started_q;
  logic [CNT_W-1:0] done_q;
  logic [BLK_W-1:0] ptr_blk_q, base_q;
  logic [PG_W-1:0]  ptr_pg_q;
  logic [PL_W-1:0]  plane_q;

  logic             q_push, q_pop, q_full, q_empty;
  logic [CMD_W-1:0] q_dout;
  logic             head_wr;
  logic [BLK_W-1:0] head_blk;
  logic [PG_W-1:0]  head_pg;
  logic [CNT_W-1:0] head_cnt;
  chk_e             verdict;

  logic [BLK_W-1:0] nxt_blk;
  logic [PG_W-1:0]  nxt_pg;
  logic [PL_W-1:0]  nxt_plane;
  logic             start, consume, last;

  logic             cmd_err_q, drop_err_q;
  logic             xfer_ok_q, dev_req_q, dev_wr_q, dev_load_q;
  logic [BLK_W-1:0] xfer_blk_q, dev_blk_q;
  logic [PG_W-1:0]  xfer_pg_q, dev_pg_q;

  ra_cmd_check #(.BLK_W(BLK_W), .CNT_W(CNT_W), .PLANES(PLANES)) u_check (
    .mp_i(mode_q), .blk_i(cmd_blk_i), .cnt_i(cmd_cnt_i), .verdict_o(verdict)
  );

  assign q_push = cmd_valid_i && !q_full && (verdict == CHK_OK);

  ra_cmd_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(q_push), .din_i({cmd_write_i, cmd_blk_i, cmd_pg_i, cmd_cnt_i}),
    .pop_i(q_pop), .dout_o(q_dout), .full_o(q_full), .empty_o(q_empty)
  );

  assign {head_wr, head_blk, head_pg, head_cnt} = q_dout;

  ra_addr_step #(.BLK_W(BLK_W), .PG_W(PG_W), .PL_W(PL_W), .PLANES(PLANES)) u_step (
    .mp_i(mode_q), .blk_i(ptr_blk_q), .pg_i(ptr_pg_q), .plane_i(plane_q),
    .base_i(base_q), .blk_o(nxt_blk), .pg_o(nxt_pg), .plane_o(nxt_plane)
  );

  assign start   = !q_empty && !started_q;
  assign consume = started_q && host_xfer_i && (host_xfer_wr_i == head_wr);
  assign last    = consume && (done_q == head_cnt - CNT_W'(1));
  assign q_pop   = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      mode_err_q <= 1'b0;
      started_q  <= 1'b0;
      done_q     <= '0;
      ptr_blk_q  <= '0;
      ptr_pg_q   <= '0;
      base_q     <= '0;
      plane_q    <= '0;
      cmd_err_q  <= 1'b0;
      drop_err_q <= 1'b0;
      xfer_ok_q  <= 1'b0;
      xfer_blk_q <= '0;
      xfer_pg_q  <= '0;
      dev_req_q  <= 1'b0;
      dev_wr_q   <= 1'b0;
      dev_load_q <= 1'b0;
      dev_blk_q  <= '0;
      dev_pg_q   <= '0;
    end else begin
      cmd_err_q  <= cmd_valid_i && q_full;
      drop_err_q <= cmd_valid_i && !q_full && (verdict != CHK_OK);
      xfer_ok_q  <= 1'b0;
      dev_req_q  <= 1'b0;

      if (mode_wr_i) begin
        if (q_empty) mode_q     <= mode_val_i;
        else         mode_err_q <= 1'b1;
      end

      if (start) begin
        started_q <= 1'b1;
        done_q    <= '0;
        ptr_blk_q <= head_blk;
        ptr_pg_q  <= head_pg;
        base_q    <= head_blk;
        plane_q   <= '0;
        if (!head_wr) begin
          dev_req_q  <= 1'b1;
          dev_wr_q   <= 1'b0;
          dev_load_q <= 1'b1;
          dev_blk_q  <= head_blk;
          dev_pg_q   <= head_pg;
        end
      end else if (consume) begin
        done_q     <= done_q + CNT_W'(1);
        ptr_blk_q  <= nxt_blk;
        ptr_pg_q   <= nxt_pg;
        plane_q    <= nxt_plane;
        xfer_ok_q  <= 1'b1;
        xfer_blk_q <= ptr_blk_q;
        xfer_pg_q  <= ptr_pg_q;
        if (head_wr) begin
          dev_req_q  <= 1'b1;
          dev_wr_q   <= 1'b1;
          dev_load_q <= 1'b0;
          dev_blk_q  <= ptr_blk_q;
          dev_pg_q   <= ptr_pg_q;
        end else if (!last) begin
          // keep the device one page ahead of the host
          dev_req_q  <= 1'b1;
          dev_wr_q   <= 1'b0;
          dev_load_q <= 1'b0;
          dev_blk_q  <= nxt_blk;
          dev_pg_q   <= nxt_pg;
        end
        if (last) started_q <= 1'b0;
      end
    end
  end

  assign cmd_full_o = q_full;
  assign cmd_err_o  = cmd_err_q;
  assign drop_err_o = drop_err_q;
  assign busy_o     = !q_empty;
  assign mode_o     = mode_q;
  assign mode_err_o = mode_err_q;
  assign xfer_ok_o  = xfer_ok_q;
  assign xfer_blk_o = xfer_blk_q;
  assign xfer_pg_o  = xfer_pg_q;
  assign dev_req_o  = dev_req_q;
  assign dev_wr_o   = dev_wr_q;
  assign dev_load_o = dev_load_q;
  assign dev_blk_o  = dev_blk_q;
  assign dev_pg_o   = dev_pg_q;

  p_full_reject_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_full_o |=> cmd_err_o && !drop_err_o);
  p_zero_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_full_o && (cmd_cnt_i == '0) |=> drop_err_o);
  p_idle_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started_q) && !head_wr |-> dev_req_o && dev_load_o && !dev_wr_o);
  p_plane_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && mode_q |-> (ptr_blk_q - base_q) < BLK_W'(PLANES));
  p_cache_after_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o && !dev_load_o |-> $past(host_xfer_i));
  p_hold_until_drained_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && !host_xfer_i |=> started_q);
  p_idle_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_xfer_i && !started_q |=> !xfer_ok_o);
  p_mode_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && busy_o |=> $stable(mode_o) && mode_err_o);
endmodule

// File: tb/flash_ra_seq_bench.sv
`timescale 1ns/1ps
module flash_ra_seq_bench;
  localparam int BLK_W = 8, PG_W = 3, CNT_W = 6, QDEPTH = 4, PLANE_LOG2 = 2;
  localparam int PLANES = 1 << PLANE_LOG2;
  localparam int XW = BLK_W + PG_W;
  localparam int RW = 2 + XW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             cmd_valid = 0, cmd_write = 0;
  logic [BLK_W-1:0] cmd_blk = '0;
  logic [PG_W-1:0]  cmd_pg = '0;
  logic [CNT_W-1:0] cmd_cnt = '0;
  logic             mode_wr = 0, mode_val = 0, host_xfer = 0, host_xfer_wr = 0;
  logic cmd_full, cmd_err, drop_err, busy, mode, mode_err, xfer_ok;
  logic dev_req, dev_wr, dev_load;
  logic [BLK_W-1:0] xfer_blk, dev_blk;
  logic [PG_W-1:0]  xfer_pg, dev_pg;

  flash_ra_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W), .QDEPTH(QDEPTH),
                 .PLANE_LOG2(PLANE_LOG2)) u_flash_ra_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write), .cmd_blk_i(cmd_blk),
    .cmd_pg_i(cmd_pg), .cmd_cnt_i(cmd_cnt), .cmd_full_o(cmd_full),
    .cmd_err_o(cmd_err), .drop_err_o(drop_err), .busy_o(busy),
    .mode_wr_i(mode_wr), .mode_val_i(mode_val), .mode_o(mode), .mode_err_o(mode_err),
    .host_xfer_i(host_xfer), .host_xfer_wr_i(host_xfer_wr), .xfer_ok_o(xfer_ok),
    .xfer_blk_o(xfer_blk), .xfer_pg_o(xfer_pg), .dev_req_o(dev_req),
    .dev_wr_o(dev_wr), .dev_load_o(dev_load), .dev_blk_o(dev_blk), .dev_pg_o(dev_pg)
  );

  int checks = 0, errors = 0;
  logic [RW-1:0] req_exp [$];
  logic [XW-1:0] xfer_exp [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model of page k's address, from the requirements
  function automatic logic [XW-1:0] addr_of(input logic mp, input logic [BLK_W-1:0] b,
                                            input logic [PG_W-1:0] p, input int k);
    int lin;
    if (mp) return {BLK_W'(b + BLK_W'(k % PLANES)), PG_W'(p + PG_W'(k / PLANES))};
    lin = int'(p) + k;
    return {BLK_W'(b + BLK_W'(lin >> PG_W)), PG_W'(lin)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_req) begin
        checks++;
        if (req_exp.size() == 0) begin
          errors++;
          $display("FAIL R6/R7/R8 unexpected request: actual %h expected none",
                   {dev_wr, dev_load, dev_blk, dev_pg});
        end else begin
          logic [RW-1:0] e;
          e = req_exp.pop_front();
          if ({dev_wr, dev_load, dev_blk, dev_pg} !== e) begin
            errors++;
            $display("FAIL R3/R4/R5/R6/R7 request: actual %h expected %h",
                     {dev_wr, dev_load, dev_blk, dev_pg}, e);
          end
        end
      end
      if (xfer_ok) begin
        checks++;
        if (xfer_exp.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected transfer: actual %h expected none", {xfer_blk, xfer_pg});
        end else begin
          logic [XW-1:0] e;
          e = xfer_exp.pop_front();
          if ({xfer_blk, xfer_pg} !== e) begin
            errors++;
            $display("FAIL R4/R5/R6 transfer address: actual %h expected %h",
                     {xfer_blk, xfer_pg}, e);
          end
        end
      end
    end
  end

  task automatic send_cmd(input logic wr, input int b, input int p, input int n);
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_blk = BLK_W'(b); cmd_pg = PG_W'(p); cmd_cnt = CNT_W'(n);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic host_acc(input logic wr);
    @(negedge clk);
    host_xfer = 1; host_xfer_wr = wr;
    @(posedge clk);
    @(negedge clk);
    host_xfer = 0;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk);
    mode_wr = 1; mode_val = v;
    @(posedge clk);
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic expect_load(input logic mp, input int b, input int p);
    req_exp.push_back({1'b0, 1'b1, addr_of(mp, BLK_W'(b), PG_W'(p), 0)});
  endtask

  task automatic drain(input logic wr, input logic mp, input int b, input int p, input int n);
    for (int k = 0; k < n; k++) begin
      xfer_exp.push_back(addr_of(mp, BLK_W'(b), PG_W'(p), k));
      if (wr) req_exp.push_back({1'b1, 1'b0, addr_of(mp, BLK_W'(b), PG_W'(p), k)});
      else if (k + 1 < n) req_exp.push_back({1'b0, 1'b0, addr_of(mp, BLK_W'(b), PG_W'(p), k + 1)});
      host_acc(wr);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_full && !mode && !mode_err, "R11 reset state", busy, 0);
    chk(!dev_req && !xfer_ok && !cmd_err && !drop_err, "R11 reset pulses", dev_req, 0);
    rst_n = 1;

    // idle host access ignored
    host_acc(0);
    chk(!xfer_ok && !dev_req, "R9 idle access", xfer_ok, 0);

    // consecutive read with page carry
    expect_load(0, 3, 6);
    send_cmd(0, 3, 6, 4);
    chk(busy, "R8 busy while held", busy, 1);
    @(negedge clk);
    chk(dev_req && dev_load, "R3 load timing", dev_req, 1);
    host_acc(1);
    chk(!xfer_ok && !dev_req, "R9 direction mismatch", xfer_ok, 0);
    drain(0, 0, 3, 6, 4);
    repeat (2) @(negedge clk);
    chk(!busy, "R8 idle after drain", busy, 0);

    // write-ahead
    send_cmd(1, 10, 2, 3);
    @(negedge clk);
    chk(!dev_req, "R7 no request at start", dev_req, 0);
    drain(1, 0, 10, 2, 3);

    // mode lock
    expect_load(0, 20, 0);
    send_cmd(0, 20, 0, 1);
    set_mode(1);
    chk(mode == 0, "R10 mode held while busy", mode, 0);
    chk(mode_err == 1, "R10 mode error flag", mode_err, 1);
    drain(0, 0, 20, 0, 1);
    repeat (2) @(negedge clk);
    set_mode(1);
    chk(mode == 1, "R10 mode write when empty", mode, 1);

    // drops in plane mode
    send_cmd(0, 6, 0, 4);
    chk(drop_err && !busy, "R2 misaligned block", drop_err, 1);
    send_cmd(0, 8, 0, 6);
    chk(drop_err && !busy, "R2 misaligned count", drop_err, 1);
    send_cmd(0, 8, 0, 0);
    chk(drop_err && !busy, "R2 zero count", drop_err, 1);

    // plane-interleaved read and write
    expect_load(1, 4, 6);
    send_cmd(0, 4, 6, 8);
    chk(!drop_err, "R2 aligned accepted", drop_err, 0);
    drain(0, 1, 4, 6, 8);
    send_cmd(1, 12, 1, 4);
    drain(1, 1, 12, 1, 4);
    repeat (2) @(negedge clk);
    set_mode(0);
    chk(mode == 0, "R10 mode back to consecutive", mode, 0);

    // fill the shared queue
    expect_load(0, 40, 0);
    send_cmd(0, 40, 0, 2);
    send_cmd(0, 41, 1, 2);
    send_cmd(1, 42, 2, 2);
    send_cmd(0, 43, 3, 2);
    chk(cmd_full, "R1 full at depth", cmd_full, 1);
    send_cmd(0, 50, 0, 2);
    chk(cmd_err, "R1 reject when full", cmd_err, 1);
    drain(0, 0, 40, 0, 2);
    expect_load(0, 41, 1);
    drain(0, 0, 41, 1, 2);
    drain(1, 0, 42, 2, 2);
    expect_load(0, 43, 3);
    drain(0, 0, 43, 3, 2);
    repeat (4) @(negedge clk);
    chk(!busy, "R8 queue drained", busy, 0);
    chk(req_exp.size() == 0, "R6 all requests seen", req_exp.size(), 0);
    chk(xfer_exp.size() == 0, "R1 all transfers seen", xfer_exp.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule